// File: doc/BRIEF.md
# Clock Mode Controller

This block steers a clock generator through its operating modes under register control. Software writes three control registers over a simple write/read bus. The block decodes the requested combination of source select, internal-reference select, low-power flag and PLL select into one of five modes. It accepts the write only when the new mode is a legal single step from the current one. It drives the effective divider, multiplier and PLL-select settings, and it reports each source handover in a status register that lags the request by a programmable number of reference cycles.

The five modes are internal-reference FLL, external bypassed, low-power bypassed, PLL-bypassed external and PLL engaged. The path to PLL engaged runs from the internal FLL to external bypassed, optionally through the low-power bypass, then to PLL-bypassed and finally to PLL engaged. PLL lock is modelled by a counter that runs while the PLL is enabled. While the low-power bypass is active, divider, multiplier and PLL-select writes are stored but held back from the outputs until that mode is left. The bus clock is reported as the generator output divided by two.

Top module: `clkModeCtrl`

## Requirements
- R1: After reset the mode is 0 (internal FLL), the status register (address 3) reads 0x10 and control register 1 (address 0) reads 0x04.
- R2: Accepted writes read back at the same address with unused bits as zero: address 0 keeps bits 7:2 (source select 7:6, divider 5:3, internal-reference select 2), address 1 keeps bit 3 (low-power flag), address 2 keeps bits 6 (PLL select) and 3:0 (multiplier). Rejected writes leave the register unchanged.
- R3: Modes are encoded 0 internal FLL (select 00, internal ref 1, PLL 0, low-power 0), 1 external bypassed (select 10, internal ref 0, PLL 0, low-power 0), 2 low-power bypassed (select 10, internal ref 0, low-power 1), 3 PLL bypassed (select 10, internal ref 0, PLL 1, low-power 0), 4 PLL engaged (select 00, internal ref 0, PLL 1, low-power 0). An accepted write changes the mode at the same clock edge.
- R4: A write that leaves mode 0 is ignored while the external-reference-ready input is low.
- R5: A write whose resulting combination is no mode, or is a mode that is not one step away along the allowed path (0-1, 1-2, 1-3, 2-3, 3-4, both directions), is ignored.
- R6: Status bit 4 (internal reference), bit 5 (PLL selected) and bits 3:2 (clock status: 00 FLL, 10 external, 11 PLL) take their new value exactly SYNC_DLY cycles after the mode-changing edge.
- R7: The lock flag (status bit 6) sets LOCK_CYCLES cycles after mode 3 is entered and clears at the edge of an accepted write that changes the divider or multiplier.
- R8: A write requesting mode 4 is ignored while the lock flag is clear.
- R9: In mode 2 the divider, multiplier and PLL-select outputs keep the values they had on entry; they take the stored register values in the cycle the mode leaves 2.
- R10: Clock status reports 11 only in mode 4 with lock set; the source select output is 00 in mode 4.
- R11: The bus divide output reports log2 of the bus divider, 1 (divide by two) by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address, 3 is status |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| extRefReady | input | 1 | External reference is running |
| modeOut | output | 3 | Current mode code |
| srcSel | output | 2 | Selected source code |
| refDivOut | output | 3 | Effective reference divider code |
| vcoMulOut | output | 4 | Effective multiplier code |
| pllSelOut | output | 1 | Effective PLL select |
| busDivLog2 | output | 2 | Bus clock divide as a power of two |

## Verification
A wrong mode register shows at modeOut in the cycle after the faulty write, and again SYNC_DLY cycles later as a wrong internal-reference or clock-status field. A broken lock counter shows as a lock flag that rises early, late or not at all, and as PEE requests that are wrongly granted or refused. Broken staging shows in the first cycle of the low-power bypass, as a divider or multiplier output that follows a write it should have held back. The random phase compares every accepted or refused write against a mode model, so a wrongly granted step shows at modeOut at once.

// File: rtl/clkModePkg.sv
`timescale 1ns/1ps
package clkModePkg;
  typedef enum logic [2:0] {
    MODE_INT_FLL = 3'd0,
    MODE_EXT_BYP = 3'd1,
    MODE_EXT_LP  = 3'd2,
    MODE_PLL_BYP = 3'd3,
    MODE_PLL_ON  = 3'd4
  } clkMode_t;

  typedef struct packed {
    logic wrC1;
    logic wrC2;
    logic wrC3;
  } regStrobe_t;

  localparam logic [1:0] ADDR_C1 = 2'd0;
  localparam logic [1:0] ADDR_C2 = 2'd1;
  localparam logic [1:0] ADDR_C3 = 2'd2;
  localparam logic [1:0] ADDR_ST = 2'd3;
  localparam logic [1:0] SEL_LOOP = 2'b00;
  localparam logic [1:0] SEL_EXT  = 2'b10;

  // legal single steps along the mode path, both directions
  function automatic logic modesAdjacent(clkMode_t a, clkMode_t b);
    logic r;
    r = (a == b);
    r |= (a == MODE_INT_FLL && b == MODE_EXT_BYP) || (a == MODE_EXT_BYP && b == MODE_INT_FLL);
    r |= (a == MODE_EXT_BYP && b == MODE_EXT_LP)  || (a == MODE_EXT_LP  && b == MODE_EXT_BYP);
    r |= (a == MODE_EXT_BYP && b == MODE_PLL_BYP) || (a == MODE_PLL_BYP && b == MODE_EXT_BYP);
    r |= (a == MODE_EXT_LP  && b == MODE_PLL_BYP) || (a == MODE_PLL_BYP && b == MODE_EXT_LP);
    r |= (a == MODE_PLL_BYP && b == MODE_PLL_ON)  || (a == MODE_PLL_ON  && b == MODE_PLL_BYP);
    return r;
  endfunction
endpackage

// File: rtl/clkModeCtl.sv
`timescale 1ns/1ps
module clkModeCtl
  import clkModePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [1:0] wrSel,
  input  logic       wrIref,
  input  logic       wrLp,
  input  logic       wrPll,
  input  logic       extRefReady,
  input  logic       lockFlag,
  input  logic [1:0] liveSel,
  input  logic       liveIref,
  input  logic       liveLp,
  input  logic       livePll,
  output clkMode_t   mode,
  output regStrobe_t strobe
);
  logic [1:0] candSel;
  logic candIref, candLp, candPll, candValid, accept;
  clkMode_t candMode;

  always_comb begin
    candSel  = liveSel;
    candIref = liveIref;
    candLp   = liveLp;
    candPll  = livePll;
    case (addr)
      ADDR_C1: begin candSel = wrSel; candIref = wrIref; end
      ADDR_C2: candLp = wrLp;
      ADDR_C3: candPll = wrPll;
      default: ;
    endcase
    candValid = 1'b1;
    candMode  = mode;
    if (candSel == SEL_LOOP && candIref && !candPll && !candLp)       candMode = MODE_INT_FLL;
    else if (candSel == SEL_EXT && !candIref && candLp)               candMode = MODE_EXT_LP;
    else if (candSel == SEL_EXT && !candIref && !candPll)             candMode = MODE_EXT_BYP;
    else if (candSel == SEL_EXT && !candIref && candPll)              candMode = MODE_PLL_BYP;
    else if (candSel == SEL_LOOP && !candIref && candPll && !candLp)  candMode = MODE_PLL_ON;
    else candValid = 1'b0;

    accept = wrEn && (addr != ADDR_ST) && candValid && modesAdjacent(mode, candMode)
          && (candMode != MODE_PLL_ON || mode == MODE_PLL_ON || lockFlag)
          && (mode != MODE_INT_FLL || candMode == MODE_INT_FLL || extRefReady);

    strobe.wrC1 = accept && (addr == ADDR_C1);
    strobe.wrC2 = accept && (addr == ADDR_C2);
    strobe.wrC3 = accept && (addr == ADDR_C3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       mode <= MODE_INT_FLL;
    else if (accept) mode <= candMode;
  end
endmodule

// File: rtl/clkModeDp.sv
`timescale 1ns/1ps
module clkModeDp
  import clkModePkg::*;
#(
  parameter int SYNC_DLY    = 3,
  parameter int LOCK_CYCLES = 16
)(
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strobe,
  input  logic [7:0] wrData,
  input  logic [1:0] addr,
  input  clkMode_t   mode,
  output logic [1:0] liveSel,
  output logic       liveIref,
  output logic       liveLp,
  output logic       livePll,
  output logic       lockFlag,
  output logic [2:0] effDiv,
  output logic [3:0] effVco,
  output logic       effPll,
  output logic [7:0] rdData
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam int ST_W  = 4; // {internal ref, pll selected, clock status[1:0]}

  logic [2:0] liveDiv, heldDiv;
  logic [3:0] liveVco, heldVco;
  logic heldPll;
  logic [CNT_W-1:0] lockCnt;
  logic [ST_W-1:0] stTarget, syncOut;

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveSel <= SEL_LOOP; liveDiv <= '0; liveIref <= 1'b1;
      liveLp  <= 1'b0;     livePll <= 1'b0; liveVco <= '0;
    end else begin
      if (strobe.wrC1) {liveSel, liveDiv, liveIref} <= wrData[7:2];
      if (strobe.wrC2) liveLp <= wrData[3];
      if (strobe.wrC3) begin livePll <= wrData[6]; liveVco <= wrData[3:0]; end
    end
  end

  // staging: copies frozen while in the low-power bypass
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldDiv <= '0; heldVco <= '0; heldPll <= 1'b0;
    end else if (mode != MODE_EXT_LP) begin
      heldDiv <= liveDiv; heldVco <= liveVco; heldPll <= livePll;
    end
  end

  assign effDiv = (mode == MODE_EXT_LP) ? heldDiv : liveDiv;
  assign effVco = (mode == MODE_EXT_LP) ? heldVco : liveVco;
  assign effPll = (mode == MODE_EXT_LP) ? heldPll : livePll;

  // lock model
  logic pllActive, setChg;
  assign pllActive = (mode == MODE_PLL_BYP) || (mode == MODE_PLL_ON);
  assign setChg = (strobe.wrC1 && wrData[5:3] != liveDiv) ||
                  (strobe.wrC3 && wrData[3:0] != liveVco);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0; lockFlag <= 1'b0;
    end else if (!pllActive || setChg) begin
      lockCnt <= '0; lockFlag <= 1'b0;
    end else if (!lockFlag) begin
      if (lockCnt == CNT_W'(LOCK_CYCLES - 1)) lockFlag <= 1'b1;
      else                                    lockCnt  <= lockCnt + 1'b1;
    end
  end

  // status targets and synchronisation delay line
  always_comb begin
    stTarget = {mode == MODE_INT_FLL, effPll && (mode != MODE_EXT_LP), 2'b10};
    if (mode == MODE_INT_FLL)                 stTarget[1:0] = 2'b00;
    else if (mode == MODE_PLL_ON && lockFlag) stTarget[1:0] = 2'b11;
  end

  generate
    if (SYNC_DLY == 1) begin : g_sync1
      logic [ST_W-1:0] stage;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage <= 4'b1000;
        else       stage <= stTarget;
      assign syncOut = stage;
    end else begin : g_syncN
      logic [SYNC_DLY-1:0][ST_W-1:0] stage;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stage <= {SYNC_DLY{4'b1000}};
        else       stage <= {stage[SYNC_DLY-2:0], stTarget};
      assign syncOut = stage[SYNC_DLY-1];
    end
  endgenerate

  always_comb begin
    case (addr)
      ADDR_C1: rdData = {liveSel, liveDiv, liveIref, 2'b00};
      ADDR_C2: rdData = {4'b0000, liveLp, 3'b000};
      ADDR_C3: rdData = {1'b0, livePll, 2'b00, liveVco};
      default: rdData = {1'b0, lockFlag, syncOut[2], syncOut[3], syncOut[1:0], 2'b00};
    endcase
  end
endmodule

// File: rtl/clkModeCtrl.sv
`timescale 1ns/1ps
module clkModeCtrl
  import clkModePkg::*;
#(
  parameter int SYNC_DLY     = 3,
  parameter int LOCK_CYCLES  = 16,
  parameter int BUS_DIV_LOG2 = 1
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       extRefReady,
  output logic [2:0] modeOut,
  output logic [1:0] srcSel,
  output logic [2:0] refDivOut,
  output logic [3:0] vcoMulOut,
  output logic       pllSelOut,
  output logic [1:0] busDivLog2
);
  clkMode_t   mode;
  regStrobe_t strobe;
  logic [1:0] liveSel;
  logic liveIref, liveLp, livePll, lockFlag;

  clkModeCtl i_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrSel(wrData[7:6]), .wrIref(wrData[2]), .wrLp(wrData[3]), .wrPll(wrData[6]),
    .extRefReady(extRefReady), .lockFlag(lockFlag),
    .liveSel(liveSel), .liveIref(liveIref), .liveLp(liveLp), .livePll(livePll),
    .mode(mode), .strobe(strobe)
  );

  clkModeDp #(.SYNC_DLY(SYNC_DLY), .LOCK_CYCLES(LOCK_CYCLES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .addr(addr), .mode(mode),
    .liveSel(liveSel), .liveIref(liveIref), .liveLp(liveLp), .livePll(livePll),
    .lockFlag(lockFlag), .effDiv(refDivOut), .effVco(vcoMulOut), .effPll(pllSelOut),
    .rdData(rdData)
  );

  assign modeOut    = mode;
  assign srcSel     = liveSel;
  assign busDivLog2 = 2'(BUS_DIV_LOG2);
endmodule

// File: rtl/clkModeChk.sv
`timescale 1ns/1ps
module clkModeChk
  import clkModePkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] modeOut,
  input logic       lockFlag,
  input logic       extRefReady,
  input logic [2:0] refDivOut,
  input logic [3:0] vcoMulOut,
  input logic       pllSelOut
);
  a_r3_mode_code: assert property (@(posedge clk) disable iff (!rstN)
    modeOut <= 3'd4);

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != $past(modeOut)) |-> modesAdjacent(clkMode_t'($past(modeOut)), clkMode_t'(modeOut)));

  a_r4_ext_ready: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == MODE_EXT_BYP && $past(modeOut) == MODE_INT_FLL) |-> $past(extRefReady));

  a_r8_engage_needs_lock: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == MODE_PLL_ON && $past(modeOut) != MODE_PLL_ON) |-> $past(lockFlag));

  a_r7_lock_only_pll: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |-> ($past(modeOut) == MODE_PLL_BYP || $past(modeOut) == MODE_PLL_ON));

  a_r9_staged_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == MODE_EXT_LP && $past(modeOut) == MODE_EXT_LP)
      |-> ($stable(refDivOut) && $stable(vcoMulOut) && $stable(pllSelOut)));
endmodule

bind clkModeCtrl clkModeChk i_chk (
  .clk(clk), .rstN(rstN), .modeOut(modeOut), .lockFlag(lockFlag),
  .extRefReady(extRefReady), .refDivOut(refDivOut), .vcoMulOut(vcoMulOut),
  .pllSelOut(pllSelOut)
);

// File: tb/test_clkModeCtrl.sv
`timescale 1ns/1ps
module test_clkModeCtrl;
  localparam int SYNC  = 3;
  localparam int LOCKC = 16;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, extRefReady = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wrData = 8'h00, rdData;
  logic [2:0] modeOut, refDivOut;
  logic [1:0] srcSel, busDivLog2;
  logic [3:0] vcoMulOut;
  logic pllSelOut;

  int nChk = 0, nFail = 0;
  logic [7:0] mC1, mC2, mC3;
  int mMode, mCnt;
  logic mLock;

  always #5 clk = ~clk;

  clkModeCtrl i_clkModeCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .extRefReady(extRefReady), .modeOut(modeOut), .srcSel(srcSel), .refDivOut(refDivOut),
    .vcoMulOut(vcoMulOut), .pllSelOut(pllSelOut), .busDivLog2(busDivLog2)
  );

  // mode from register fields per R3; -1 when no mode matches
  function automatic int classify(logic [7:0] c1, logic [7:0] c2, logic [7:0] c3);
    logic [1:0] s; logic ir, lp, pl;
    s = c1[7:6]; ir = c1[2]; lp = c2[3]; pl = c3[6];
    if (s == 2'b00 && ir && !pl && !lp) return 0;
    if (s == 2'b10 && !ir && lp) return 2;
    if (s == 2'b10 && !ir && !pl) return 1;
    if (s == 2'b10 && !ir && pl) return 3;
    if (s == 2'b00 && !ir && pl && !lp) return 4;
    return -1;
  endfunction

  function automatic bit stepOk(int a, int b);
    if (a == b) return 1;
    if ((a == 0 && b == 1) || (a == 1 && b == 0)) return 1;
    if ((a == 1 && b == 2) || (a == 2 && b == 1)) return 1;
    if ((a == 1 && b == 3) || (a == 3 && b == 1)) return 1;
    if ((a == 2 && b == 3) || (a == 3 && b == 2)) return 1;
    if ((a == 3 && b == 4) || (a == 4 && b == 3)) return 1;
    return 0;
  endfunction

  // lock model per R7
  always @(posedge clk) begin
    if (!rstN) begin mCnt = 0; mLock = 1'b0; end
    else if (!(mMode == 3 || mMode == 4)) begin mCnt = 0; mLock = 1'b0; end
    else if (!mLock) begin
      if (mCnt == LOCKC - 1) mLock = 1'b1; else mCnt++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    mC1 = 8'h04; mC2 = 8'h00; mC3 = 8'h00; mMode = 0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  // write through the bus and advance the model; returns at the negedge after the edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] n1, n2, n3; int tgt; bit acc;
    @(negedge clk);
    n1 = mC1; n2 = mC2; n3 = mC3;
    if (a == 0) n1 = d & 8'hFC;
    if (a == 1) n2 = d & 8'h08;
    if (a == 2) n3 = d & 8'h4F;
    tgt = classify(n1, n2, n3);
    acc = (a != 3) && (tgt >= 0) && stepOk(mMode, tgt)
       && (tgt != 4 || mMode == 4 || mLock) && (mMode != 0 || tgt == 0 || extRefReady);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    if (acc) begin
      if ((a == 0 && n1[5:3] != mC1[5:3]) || (a == 2 && n3[3:0] != mC3[3:0])) begin
        mCnt = 0; mLock = 1'b0;
      end
      mC1 = n1; mC2 = n2; mC3 = n3; mMode = tgt;
    end
  endtask

  function automatic logic [7:0] pickData(int a);
    int k; k = $urandom % 6;
    if (a == 0) case (k) 0: return 8'h04; 1: return 8'hB8; 2: return 8'h90; 3: return 8'h10; 4: return 8'h00; default: return 8'($urandom); endcase
    if (a == 1) return (k < 3) ? 8'h08 : 8'h00;
    case (k) 0: return 8'h44; 1: return 8'h00; 2: return 8'h40; 3: return 8'h45; 4: return 8'h04; default: return 8'($urandom); endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    doReset();
    rd(3, v); chk("R1", "reset status", v, 8'h10);
    rd(0, v); chk("R1", "reset ctrl1", v, 8'h04);
    chk("R1", "reset mode", modeOut, 0);
    chk("R11", "bus divide", busDivLog2, 1);

    extRefReady = 1'b0;
    wr(0, 8'hB8); chk("R4", "mode w/o ext ref", modeOut, 0);
    rd(0, v); chk("R2", "rejected ctrl1 unchanged", v, 8'h04);
    extRefReady = 1'b1;
    wr(0, 8'h10); chk("R5", "skip to engaged", modeOut, 0);

    wr(0, 8'hBB); chk("R3", "enter ext bypass", modeOut, 1);
    rd(0, v); chk("R2", "ctrl1 readback masks", v, 8'hB8);
    chk("R3", "src select ext", srcSel, 2'b10);
    chk("R3", "divider out", refDivOut, 7);
    cyc(SYNC - 1); rd(3, v); chk("R6", "status before delay", v, 8'h10);
    cyc(1); rd(3, v); chk("R6", "status after delay", v, 8'h08);

    wr(1, 8'hFF); chk("R3", "enter low power", modeOut, 2);
    rd(1, v); chk("R2", "ctrl2 readback", v, 8'h08);
    wr(0, 8'h90); chk("R9", "divider held", refDivOut, 7);
    wr(2, 8'h44); chk("R9", "multiplier held", vcoMulOut, 0);
    chk("R9", "pll select held", pllSelOut, 0);
    chk("R9", "still low power", modeOut, 2);
    rd(2, v); chk("R2", "ctrl3 readback", v, 8'h44);
    wr(0, 8'h10); chk("R5", "engage from low power", modeOut, 2);

    wr(1, 8'h00); chk("R3", "enter pll bypass", modeOut, 3);
    chk("R9", "divider released", refDivOut, 2);
    chk("R9", "multiplier released", vcoMulOut, 4);
    chk("R9", "pll select released", pllSelOut, 1);
    cyc(LOCKC - 1); rd(3, v); chk("R7", "lock not yet", v, 8'h28);
    cyc(1); rd(3, v); chk("R7", "lock set", v, 8'h68);

    wr(2, 8'h45); rd(3, v); chk("R7", "lock drops on change", v, 8'h28);
    wr(0, 8'h10); chk("R8", "engage refused unlocked", modeOut, 3);
    cyc(LOCKC + 2);
    wr(0, 8'h10); chk("R10", "engaged", modeOut, 4);
    chk("R10", "src select loop", srcSel, 2'b00);
    cyc(SYNC - 1); rd(3, v); chk("R10", "clock status before delay", v, 8'h68);
    cyc(1); rd(3, v); chk("R10", "clock status pll", v, 8'h6C);

    // random phase against the model
    doReset();
    for (int i = 0; i < 600; i++) begin
      int a;
      extRefReady = ($urandom % 4) != 0;
      a = $urandom % 3;
      wr(2'(a), pickData(a));
      chk("R5", "random mode", modeOut, mMode);
      rd(2'(a), v);
      chk("R2", "random readback", v, (a == 0) ? mC1 : (a == 1) ? mC2 : mC3);
      rd(3, v);
      chk("R7", "random lock", v[6], mLock);
      cyc($urandom % 20);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule